// File: doc/BRIEF.md
# PHY Management Register Bank

This block is the register side of a 10/100 Ethernet PHY model as seen over a clause-22 management path. A host reaches thirty-two 16-bit locations through a 5-bit address with separate read and write strobes. Read data appears on a registered bus one cycle after the read strobe. The bank holds the control, status, advertisement, interrupt-source and interrupt-mask registers. Fixed locations return identifier words, a link-partner ability word and an expansion word. Unused locations read as zero and drop writes.

Nothing is actually negotiated. Enabling autonegotiation marks it complete at once, and the link-down input drives the link and negotiation-complete status bits directly. Every change on that input is a link event. A link event sets interrupt-source bits, and the level interrupt output is high while any source bit is also enabled in the mask. A small link tracker state machine turns the input into events. It has three states:
- `LK_APPLY`: entered on hardware reset and on soft reset. It always produces one event that matches the current link level, then moves to `LK_UP` or `LK_DOWN`.
- `LK_UP`: moves to `LK_DOWN`, with a down event, when the registered link-down input is high.
- `LK_DOWN`: moves to `LK_UP`, with an up event, when that input is low.

A soft reset forces `LK_APPLY` from any state.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After hardware reset, the registers hold these values: control 0x3000, advertisement 0x01E1, mask 0x0000, status 0x7809. The current link level is then applied as a link event. With the link up, this gives status 0x782D and interrupt source 0x00C0.
- R2: Read data is registered. It reflects the address sampled with the read strobe and is valid one cycle later. Addresses 2 and 3 return the PHY_ID_HI and PHY_ID_LO parameters.
- R3: Address 5 always reads 0x0FE1 and address 6 always reads 0x0001. Writes to addresses 1, 2, 3, 5 and 6 change nothing.
- R4: A control write (address 0) with bit 15 clear stores only bits 14, 13, 12, 11, 8 and 7 (mask 0x7980). If bit 12 is written as 1, status bit 5 (negotiation complete) is set in the same update.
- R5: A control write with bit 15 set is a soft reset. It restores every R1 register value, stores none of the other written bits, and re-applies the current link level as a link event on the next cycle.
- R6: An advertisement write (address 4) stores data AND 0x2D7F, with bit 7 (100BASE-TX half duplex) forced to 1.
- R7: Two clock edges after the link-down input rises, status bits 2 (link) and 5 (negotiation complete) are clear and interrupt-source bit 4 is set.
- R8: Two clock edges after the link-down input falls, status bits 2 and 5 are set and interrupt-source bits 7 and 6 are set.
- R9: A read of address 29 returns the interrupt-source value and clears the register to zero.
- R10: Address 30 is the interrupt mask. A write stores the low 8 bits, and a read returns them with the upper byte zero.
- R11: The interrupt output is high exactly when the interrupt source AND the mask is nonzero. It falls after a clearing read or a mask change.
- R12: A link event in the same cycle as a clearing read of address 29 is not lost: its bits are present after the clear.
- R13: Addresses 17, 18, 27, 31 and all other unassigned addresses read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| addr_i | input | 5 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 16 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 16 | Registered read data, valid the cycle after rd_en_i |
| link_down_i | input | 1 | Link level, high when the link is down |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong link tracker state shows up in two ways. The link and negotiation-complete status bits stay stale, and interrupt-source bits are missing or duplicated on the next read of address 29, two cycles after the input moved. A corrupted source or mask register shows on irq_o in the same cycle and in read data one cycle after the read strobe. The bench therefore compares both outputs against a behavioural model on every clock, so a divergence is flagged within one cycle of becoming visible.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int IRQ_W  = 8;

    typedef enum logic [1:0] {LK_APPLY, LK_UP, LK_DOWN} link_state_t;

    localparam logic [ADDR_W-1:0] A_CTRL    = 5'd0;
    localparam logic [ADDR_W-1:0] A_STAT    = 5'd1;
    localparam logic [ADDR_W-1:0] A_ID_HI   = 5'd2;
    localparam logic [ADDR_W-1:0] A_ID_LO   = 5'd3;
    localparam logic [ADDR_W-1:0] A_ADV     = 5'd4;
    localparam logic [ADDR_W-1:0] A_PARTNER = 5'd5;
    localparam logic [ADDR_W-1:0] A_EXPN    = 5'd6;
    localparam logic [ADDR_W-1:0] A_ISRC    = 5'd29;
    localparam logic [ADDR_W-1:0] A_IMASK   = 5'd30;

    localparam int CTRL_SOFTRST = 15;
    localparam int CTRL_AN_EN   = 12;
    localparam int STAT_ANDONE  = 5;
    localparam int STAT_LINK    = 2;
    localparam int ADV_100HD    = 7;

    localparam logic [DATA_W-1:0] CTRL_WMASK  = 16'h7980;
    localparam logic [DATA_W-1:0] CTRL_RST    = 16'h3000;
    localparam logic [DATA_W-1:0] STAT_RST    = 16'h7809;
    localparam logic [DATA_W-1:0] ADV_WMASK   = 16'h2D7F;
    localparam logic [DATA_W-1:0] ADV_RST     = 16'h01E1;
    localparam logic [DATA_W-1:0] PARTNER_VAL = 16'h0FE1;
    localparam logic [DATA_W-1:0] EXPN_VAL    = 16'h0001;

    localparam logic [IRQ_W-1:0] IRQ_UP_BITS   = 8'hC0;
    localparam logic [IRQ_W-1:0] IRQ_DOWN_BITS = 8'h10;
endpackage

// File: rtl/phy_link_tracker.sv
module phy_link_tracker
    import phy_mgmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic link_down_i,
    input  logic restart_i,
    output logic evt_up_o,
    output logic evt_down_o
);
    logic        link_q;
    link_state_t st_q, st_d;

    always_ff @(posedge clk) begin
        link_q <= link_down_i;
        if (!rst_n) st_q <= LK_APPLY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LK_APPLY: st_d = link_q ? LK_DOWN : LK_UP;
            LK_UP:    if (link_q)  st_d = LK_DOWN;
            LK_DOWN:  if (!link_q) st_d = LK_UP;
            default:  st_d = LK_APPLY;
        endcase
        if (restart_i) st_d = LK_APPLY;
    end

    always_comb begin
        evt_up_o   = 1'b0;
        evt_down_o = 1'b0;
        unique case (st_q)
            LK_APPLY: begin evt_up_o = !link_q; evt_down_o = link_q; end
            LK_UP:    evt_down_o = link_q;
            LK_DOWN:  evt_up_o = !link_q;
            default:  ;
        endcase
    end

    // R7
    one_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_up_o, evt_down_o}));
    // R5
    restart_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> st_q == LK_APPLY);
    // R8
    up_settles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_up_o && !restart_i) |=> st_q == LK_UP);
endmodule

// File: rtl/phy_irq_unit.sv
module phy_irq_unit
    import phy_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_i,
    input  logic             mask_we_i,
    input  logic [IRQ_W-1:0] mask_wdata_i,
    input  logic             clr_i,
    input  logic [IRQ_W-1:0] set_bits_i,
    output logic [IRQ_W-1:0] src_o,
    output logic [IRQ_W-1:0] mask_o,
    output logic             irq_o
);
    logic [IRQ_W-1:0] src_q, mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_i) begin
            src_q  <= '0;
            mask_q <= '0;
        end else begin
            src_q <= (clr_i ? '0 : src_q) | set_bits_i;
            if (mask_we_i) mask_q <= mask_wdata_i;
        end
    end

    assign src_o  = src_q;
    assign mask_o = mask_q;
    assign irq_o  = |(src_q & mask_q);

    // R9
    clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_bits_i == '0 && !soft_rst_i) |=> src_q == '0);
    // R12
    keep_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits_i != '0 && !soft_rst_i) |=> (src_q & $past(set_bits_i)) == $past(set_bits_i));
    // R10
    mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we_i && !soft_rst_i) |=> mask_q == $past(mask_wdata_i));
endmodule

// File: rtl/phy_ctrl_regs.sv
module phy_ctrl_regs
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_i,
    input  logic              ctrl_we_i,
    input  logic              adv_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              evt_up_i,
    input  logic              evt_down_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] stat_o,
    output logic [DATA_W-1:0] adv_o
);
    logic [DATA_W-1:0] ctrl_q, stat_q, adv_q, stat_d;

    always_comb begin
        stat_d = stat_q;
        if (ctrl_we_i && wdata_i[CTRL_AN_EN]) stat_d[STAT_ANDONE] = 1'b1;
        if (evt_down_i) begin
            stat_d[STAT_ANDONE] = 1'b0;
            stat_d[STAT_LINK]   = 1'b0;
        end
        if (evt_up_i) begin
            stat_d[STAT_ANDONE] = 1'b1;
            stat_d[STAT_LINK]   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_i) begin
            ctrl_q <= CTRL_RST;
            stat_q <= STAT_RST;
            adv_q  <= ADV_RST;
        end else begin
            stat_q <= stat_d;
            if (ctrl_we_i) ctrl_q <= wdata_i & CTRL_WMASK;
            if (adv_we_i) begin
                adv_q            <= wdata_i & ADV_WMASK;
                adv_q[ADV_100HD] <= 1'b1;
            end
        end
    end

    assign ctrl_o = ctrl_q;
    assign stat_o = stat_q;
    assign adv_o  = adv_q;

    // R6
    adv_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_we_i && !soft_rst_i) |=> adv_q[ADV_100HD]);
    // R7
    down_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_down_i && !soft_rst_i) |=> !stat_q[STAT_LINK] && !stat_q[STAT_ANDONE]);
    // R4
    an_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we_i && wdata_i[CTRL_AN_EN] && !evt_down_i && !soft_rst_i) |=> stat_q[STAT_ANDONE]);
    // R5
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |=> ctrl_q == CTRL_RST && adv_q == ADV_RST);
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter logic [15:0] PHY_ID_HI = 16'h2A5C,
    parameter logic [15:0] PHY_ID_LO = 16'h7E31
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  addr_i,
    input  logic        wr_en_i,
    input  logic [15:0] wr_data_i,
    input  logic        rd_en_i,
    output logic [15:0] rd_data_o,
    input  logic        link_down_i,
    output logic        irq_o
);
    logic              soft_rst, ctrl_we, adv_we, mask_we, clr;
    logic              evt_up, evt_down;
    logic [IRQ_W-1:0]  set_bits, src, mask;
    logic [DATA_W-1:0] ctrl, stat, adv, rd_mux, rd_q;

    assign soft_rst = wr_en_i && addr_i == A_CTRL && wr_data_i[CTRL_SOFTRST];
    assign ctrl_we  = wr_en_i && addr_i == A_CTRL && !wr_data_i[CTRL_SOFTRST];
    assign adv_we   = wr_en_i && addr_i == A_ADV;
    assign mask_we  = wr_en_i && addr_i == A_IMASK;
    assign clr      = rd_en_i && addr_i == A_ISRC;
    assign set_bits = evt_up ? IRQ_UP_BITS : (evt_down ? IRQ_DOWN_BITS : '0);

    phy_link_tracker u_link (
        .clk(clk), .rst_n(rst_n), .link_down_i(link_down_i),
        .restart_i(soft_rst), .evt_up_o(evt_up), .evt_down_o(evt_down)
    );

    phy_ctrl_regs u_ctrl (
        .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst),
        .ctrl_we_i(ctrl_we), .adv_we_i(adv_we), .wdata_i(wr_data_i),
        .evt_up_i(evt_up), .evt_down_i(evt_down),
        .ctrl_o(ctrl), .stat_o(stat), .adv_o(adv)
    );

    phy_irq_unit u_irq (
        .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst),
        .mask_we_i(mask_we), .mask_wdata_i(wr_data_i[IRQ_W-1:0]),
        .clr_i(clr), .set_bits_i(set_bits),
        .src_o(src), .mask_o(mask), .irq_o(irq_o)
    );

    always_comb begin
        case (addr_i)
            A_CTRL:    rd_mux = ctrl;
            A_STAT:    rd_mux = stat;
            A_ID_HI:   rd_mux = PHY_ID_HI;
            A_ID_LO:   rd_mux = PHY_ID_LO;
            A_ADV:     rd_mux = adv;
            A_PARTNER: rd_mux = PARTNER_VAL;
            A_EXPN:    rd_mux = EXPN_VAL;
            A_ISRC:    rd_mux = {{(DATA_W-IRQ_W){1'b0}}, src};
            A_IMASK:   rd_mux = {{(DATA_W-IRQ_W){1'b0}}, mask};
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       rd_q <= '0;
        else if (rd_en_i) rd_q <= rd_mux;
    end

    assign rd_data_o = rd_q;

    // R13
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (addr_i == 5'd17 || addr_i == 5'd18 || addr_i == 5'd27 || addr_i == 5'd31))
        |=> rd_data_o == '0);
    // R3
    partner_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == A_PARTNER) |=> rd_data_o == PARTNER_VAL);
    // R2
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en_i && $past(rst_n)) |=> $stable(rd_data_o));
endmodule

// File: tb/phy_mgmt_regs_test.sv
`timescale 1ns/1ps
module phy_mgmt_regs_test;
    localparam logic [15:0] ID_HI = 16'h2A5C;
    localparam logic [15:0] ID_LO = 16'h7E31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        link_down = 1'b0;
    logic        irq;

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;

    always #2 clk = ~clk;

    phy_mgmt_regs #(.PHY_ID_HI(ID_HI), .PHY_ID_LO(ID_LO)) uut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en),
        .wr_data_i(wdata), .rd_en_i(rd_en), .rd_data_o(rd_data),
        .link_down_i(link_down), .irq_o(irq)
    );

    // behavioural reference model
    logic [15:0] m_ctrl = 0, m_stat = 0, m_adv = 0, m_src = 0, m_mask = 0, m_rd = 0;
    int          m_state = 0;   // 0 apply, 1 up, 2 down
    logic        m_lq = 0;

    function automatic logic [15:0] m_read(input logic [4:0] a);
        case (a)
            0: return m_ctrl;
            1: return m_stat;
            2: return ID_HI;
            3: return ID_LO;
            4: return m_adv;
            5: return 16'h0FE1;
            6: return 16'h0001;
            29: return m_src;
            30: return m_mask;
            default: return 16'h0000;
        endcase
    endfunction

    always @(posedge clk) begin
        bit e_up, e_dn;
        e_up = 0; e_dn = 0;
        if (!rst_n) begin
            m_ctrl = 16'h3000; m_stat = 16'h7809; m_adv = 16'h01E1;
            m_src = 0; m_mask = 0; m_rd = 0; m_state = 0;
        end else begin
            if (m_state == 0) begin e_up = !m_lq; e_dn = m_lq; end
            else if (m_state == 1 && m_lq) e_dn = 1;
            else if (m_state == 2 && !m_lq) e_up = 1;
            if (rd_en) m_rd = m_read(addr);
            if (wr_en && addr == 0 && wdata[15]) begin
                m_ctrl = 16'h3000; m_stat = 16'h7809; m_adv = 16'h01E1;
                m_src = 0; m_mask = 0; m_state = 0;
            end else begin
                if (wr_en && addr == 0) begin
                    m_ctrl = wdata & 16'h7980;
                    if (wdata[12]) m_stat[5] = 1;
                end
                if (wr_en && addr == 4) m_adv = (wdata & 16'h2D7F) | 16'h0080;
                if (wr_en && addr == 30) m_mask = {8'h00, wdata[7:0]};
                if (rd_en && addr == 29) m_src = 0;
                if (e_dn) begin m_stat[5] = 0; m_stat[2] = 0; m_src = m_src | 16'h0010; m_state = 2; end
                if (e_up) begin m_stat[5] = 1; m_stat[2] = 1; m_src = m_src | 16'h00C0; m_state = 1; end
            end
        end
        m_lq = link_down;
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk({cur_req, " rd_data vs model"}, rd_data, m_rd);
            chk({cur_req, " irq vs model (R11)"}, {15'd0, irq}, {15'd0, |(m_src & m_mask)});
        end
    end

    task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string req);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        chk(req, rd_data, exp);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        cmp_on = 1'b1;
        chk("R1 reset rd_data", rd_data, 16'h0000);
        rst_n = 1'b1;
        idle(3);
        cur_req = "R1";
        rd(0, 16'h3000, "R1 control reset");
        rd(1, 16'h782D, "R1/R8 status after reset link up");
        rd(4, 16'h01E1, "R1 advertisement reset");
        rd(30, 16'h0000, "R1/R10 mask reset");
        chk("R11 irq low with zero mask", {15'd0, irq}, 16'h0000);
        cur_req = "R2";
        rd(2, ID_HI, "R2 id high");
        rd(3, ID_LO, "R2 id low");
        rd(5, 16'h0FE1, "R3 partner ability");
        rd(6, 16'h0001, "R3 expansion");
        cur_req = "R9";
        rd(29, 16'h00C0, "R9/R1 source after reset");
        rd(29, 16'h0000, "R9 source cleared");
        cur_req = "R13";
        rd(17, 16'h0000, "R13 reg17");
        rd(31, 16'h0000, "R13 reg31");
        rd(9, 16'h0000, "R13 undefined");
        wr(17, 16'hFFFF);
        rd(17, 16'h0000, "R13 write ignored");

        cur_req = "R4";
        wr(0, 16'h7FFF);
        rd(0, 16'h7980, "R4 control filter");
        cur_req = "R7";
        @(negedge clk); link_down = 1'b1;
        idle(3);
        rd(1, 16'h7809, "R7 status link down");
        rd(29, 16'h0010, "R7 down source bit");
        cur_req = "R4";
        wr(0, 16'h1000);
        rd(1, 16'h7829, "R4 negotiation complete on enable");
        rd(0, 16'h1000, "R4 control value");

        cur_req = "R6";
        wr(4, 16'hFFFF);
        rd(4, 16'h2DFF, "R6 advert filter all ones");
        wr(4, 16'h0000);
        rd(4, 16'h0080, "R6 advert forced half");

        cur_req = "R3";
        wr(1, 16'h0000); wr(2, 16'h0000); wr(3, 16'h0000);
        wr(5, 16'h0000); wr(6, 16'hFFFF);
        rd(1, 16'h7829, "R3 status write ignored");
        rd(2, ID_HI, "R3 id write ignored");
        rd(5, 16'h0FE1, "R3 partner write ignored");
        rd(6, 16'h0001, "R3 expansion write ignored");

        cur_req = "R10";
        wr(30, 16'hFFFF);
        rd(30, 16'h00FF, "R10 mask low byte");
        cur_req = "R8";
        @(negedge clk); link_down = 1'b0;
        idle(3);
        chk("R11 irq on up event", {15'd0, irq}, 16'h0001);
        rd(1, 16'h782D, "R8 status link up");
        rd(29, 16'h00C0, "R8/R9 up source bits");
        chk("R11 irq low after clear", {15'd0, irq}, 16'h0000);
        cur_req = "R11";
        wr(30, 16'h0010);
        @(negedge clk); link_down = 1'b1;
        idle(3);
        chk("R11 irq masked down bit", {15'd0, irq}, 16'h0001);
        wr(30, 16'h0000);
        chk("R11 irq low after mask clear", {15'd0, irq}, 16'h0000);
        rd(29, 16'h0010, "R11 source kept under mask");

        cur_req = "R12";
        @(negedge clk); link_down = 1'b0;
        @(negedge clk); addr = 29; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        rd(29, 16'h00C0, "R12 event kept over clear");

        cur_req = "R5";
        wr(30, 16'h00FF);
        wr(0, 16'h4000);
        wr(4, 16'h0000);
        wr(0, 16'hC000);
        idle(2);
        rd(0, 16'h3000, "R5 control restored");
        rd(4, 16'h01E1, "R5 advert restored");
        rd(30, 16'h0000, "R5 mask restored");
        rd(1, 16'h782D, "R5 link reapplied status");
        rd(29, 16'h00C0, "R5 link reapplied source");

        cur_req = "R1";
        @(negedge clk); rst_n = 1'b0; link_down = 1'b1;
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        idle(3);
        rd(1, 16'h7809, "R1 reset with link down status");
        rd(29, 16'h0010, "R1 reset with link down source");
        idle(2);
        finish_run();
    end
endmodule